// File: doc/BRIEF.md
# SPI channel transfer sequencer

This block is a single serial-peripheral channel as it sits behind a register bus. Software (or a DMA engine) loads a configuration word, enables the channel and writes transmit words. The channel then clocks each word out on MOSI, most significant bit first, while it samples MISO into a receive word. A small set of status flags tracks whether the transmit holding register is free, whether a received word is waiting and whether the last word has finished.

Those flags, together with the enable bit and a two-bit transfer-mode field, decide when the next word may start. The mode is full duplex, receive only or transmit only. A turbo bit lets a new word start while a received word is still unread. A module-level single-channel input and a per-channel force bit decide whether the serial pins actually toggle. If they do not, the word completes at once with no wire activity. The block produces level DMA requests for each direction and single-cycle event pulses that an interrupt collector can latch.

Top module: `spi_chan_seq`

## Requirements
- R1: After reset, status_o is 3'b010, cfg_o is 23'h060000, en_o, busy_o, sclk_o and both DMA requests are low, and tx_data_o and rx_data_o are zero.
- R2: The word length is cfg_o[11:7] plus one. Bits leave on mosi_o MSB first with SPI mode 0 timing: sclk_o idles low, MISO is sampled on its rising edge and MOSI changes on its falling edge. The sclk_o half period is CLK_DIV clocks. The received word is right-aligned in rx_data_o with zero upper bits.
- R3: Status bit 0 is receive-full, bit 1 transmit-empty and bit 2 end-of-transfer. The mode field cfg_o[13:12] is 0 for duplex, 1 for receive only and 2 for transmit only. When a word completes, tx_data_o clears, end-of-transfer and transmit-empty set, and receive-full sets unless the mode is 2.
- R4: A write strobe on the transmit register stores the word, clears transmit-empty and requests a start. A receive read strobe clears receive-full and requests a start. A control write that raises the enable bit (wdata_i[0]) requests a start. No word starts while the channel is disabled.
- R5: A start is refused while transmit-empty is set and the mode is not 1. It is also refused while receive-full is set, the mode is not 2 and turbo (cfg_o[19]) is clear.
- R6: When single_mode_i is high and the force bit cfg_o[20] is clear, a word completes without any sclk_o edge, rx_data_o keeps its old value, and the flags still update as in R3.
- R7: tx_dreq_o = enabled AND cfg_o[14] AND transmit-empty AND mode != 1. rx_dreq_o = enabled AND cfg_o[15] AND receive-full AND mode != 2.
- R8: tx_empty_evt_o pulses for one cycle when (enabled AND transmit-empty AND mode != 1) becomes true. rx_full_evt_o pulses for one cycle when (enabled AND receive-full AND mode != 2 AND turbo clear) becomes true.
- R9: busy_o is high from the start of a word until it completes. End-of-transfer reads zero during that time, and no other word can start.
- R10: A configuration write keeps wdata_i[22:0] and drops the upper bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| single_mode_i | input | 1 | Module-level single-channel mode; gates the wire unless forced |
| wr_cfg_i | input | 1 | Configuration write strobe |
| wr_ctrl_i | input | 1 | Control (enable) write strobe |
| wr_tx_i | input | 1 | Transmit register write strobe |
| rd_rx_i | input | 1 | Receive register read strobe |
| wdata_i | input | DATA_W | Write data for the strobes above |
| cfg_o | output | 23 | Configuration word |
| status_o | output | 3 | Receive-full, transmit-empty, end-of-transfer |
| en_o | output | 1 | Channel enable |
| tx_data_o | output | DATA_W | Transmit holding register |
| rx_data_o | output | DATA_W | Receive register |
| busy_o | output | 1 | A word is in flight |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| tx_dreq_o | output | 1 | Transmit DMA request level |
| rx_dreq_o | output | 1 | Receive DMA request level |
| tx_empty_evt_o | output | 1 | Transmit-empty event pulse |
| rx_full_evt_o | output | 1 | Receive-full event pulse |

## Verification
The bench attacks the start gate from each side. A transmit write that lands while an unread word sits in receive mode must wait for the receive read; a design that ignores receive-full would overwrite that unread word. With turbo set, or in receive-only mode with transmit-empty set, the word must go anyway; a gate that applies every stall in every mode would hang there. The shortest (4-bit) and longest (32-bit) word lengths show up misplaced MSB indexing or a receive word that is not right-aligned. The unforced single-channel case shows a design that toggles the wire or overwrites rx_data_o when it should only update flags.

// File: rtl/spi_seq_pkg.sv
package spi_seq_pkg;

  typedef enum logic [1:0] {
    XM_DUPLEX  = 2'd0,
    XM_RX_ONLY = 2'd1,
    XM_TX_ONLY = 2'd2,
    XM_BAD     = 2'd3
  } xfer_mode_e;

  // status word bit positions
  localparam int ST_RXF = 0;
  localparam int ST_TXE = 1;
  localparam int ST_EOT = 2;
  localparam int ST_W   = 3;

  // configuration word fields
  localparam int CFG_W       = 23;
  localparam int CF_WL_LSB   = 7;
  localparam int CF_WL_W     = 5;
  localparam int CF_MODE_LSB = 12;
  localparam int CF_TXDMA    = 14;
  localparam int CF_RXDMA    = 15;
  localparam int CF_TURBO    = 19;
  localparam int CF_FORCE    = 20;

  localparam logic [CFG_W-1:0] CFG_RST = 23'h060000;
  localparam logic [ST_W-1:0]  ST_RST  = 3'b010;

endpackage

// File: rtl/spi_seq_shift.sv
module spi_seq_shift #(
  parameter int DATA_W  = 32,
  parameter int CLK_DIV = 2,
  parameter int LEN_W   = $clog2(DATA_W) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              wire_i,
  input  logic [DATA_W-1:0] word_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic              miso_i,
  output logic              busy_o,
  output logic              sclk_o,
  output logic              mosi_o,
  output logic              done_o,
  output logic              capt_o,
  output logic [DATA_W-1:0] rx_word_o
);
  localparam int DIV_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;

  logic              busy_q, busy_d;
  logic              sclk_q, sclk_d;
  logic              wire_q, wire_d;
  logic [DIV_W-1:0]  div_q, div_d;
  logic [LEN_W-1:0]  cnt_q, cnt_d;
  logic [DATA_W-1:0] tsh_q, tsh_d;
  logic [DATA_W-1:0] rsh_q, rsh_d;
  logic              tick, last;

  assign tick = (div_q == DIV_W'(CLK_DIV - 1));
  assign last = sclk_q && tick && (cnt_q == LEN_W'(1));

  always_comb begin
    busy_d = busy_q;
    sclk_d = sclk_q;
    wire_d = wire_q;
    div_d  = div_q;
    cnt_d  = cnt_q;
    tsh_d  = tsh_q;
    rsh_d  = rsh_q;
    if (start_i) begin
      busy_d = 1'b1;
      wire_d = wire_i;
      div_d  = '0;
      cnt_d  = len_i;
      sclk_d = 1'b0;
      tsh_d  = word_i << (LEN_W'(DATA_W) - len_i);
      rsh_d  = '0;
    end else if (busy_q) begin
      if (!wire_q) begin
        busy_d = 1'b0;
      end else begin
        div_d = tick ? '0 : div_q + DIV_W'(1);
        if (tick) begin
          if (!sclk_q) begin
            sclk_d = 1'b1;
            rsh_d  = {rsh_q[DATA_W-2:0], miso_i};
          end else begin
            sclk_d = 1'b0;
            tsh_d  = tsh_q << 1;
            cnt_d  = cnt_q - LEN_W'(1);
            if (cnt_q == LEN_W'(1)) busy_d = 1'b0;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      sclk_q <= 1'b0;
      wire_q <= 1'b0;
      div_q  <= '0;
      cnt_q  <= '0;
      tsh_q  <= '0;
      rsh_q  <= '0;
    end else begin
      busy_q <= busy_d;
      sclk_q <= sclk_d;
      wire_q <= wire_d;
      div_q  <= div_d;
      cnt_q  <= cnt_d;
      tsh_q  <= tsh_d;
      rsh_q  <= rsh_d;
    end
  end

  assign busy_o    = busy_q;
  assign sclk_o    = sclk_q;
  assign mosi_o    = busy_q && wire_q && tsh_q[DATA_W-1];
  assign done_o    = busy_q && (!wire_q || last);
  assign capt_o    = busy_q && wire_q && last;
  assign rx_word_o = rsh_q;
endmodule

// File: rtl/spi_seq_flags.sv
module spi_seq_flags
  import spi_seq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en_i,
  input  xfer_mode_e      mode_i,
  input  logic            turbo_i,
  input  logic            txdma_i,
  input  logic            rxdma_i,
  input  logic [ST_W-1:0] stat_i,
  output logic            tx_dreq_o,
  output logic            rx_dreq_o,
  output logic            tx_evt_o,
  output logic            rx_evt_o
);
  logic tx_ready, rx_ready, rx_live;
  logic tx_live_q, rx_live_q;

  assign tx_ready = en_i && stat_i[ST_TXE] && (mode_i != XM_RX_ONLY);
  assign rx_ready = en_i && stat_i[ST_RXF] && (mode_i != XM_TX_ONLY);
  assign rx_live  = rx_ready && !turbo_i;

  assign tx_dreq_o = tx_ready && txdma_i;
  assign rx_dreq_o = rx_ready && rxdma_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_live_q <= 1'b0;
      rx_live_q <= 1'b0;
    end else begin
      tx_live_q <= tx_ready;
      rx_live_q <= rx_live;
    end
  end

  assign tx_evt_o = tx_ready && !tx_live_q;
  assign rx_evt_o = rx_live && !rx_live_q;
endmodule

// File: rtl/spi_chan_seq.sv
module spi_chan_seq
  import spi_seq_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int CLK_DIV = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              single_mode_i,
  input  logic              wr_cfg_i,
  input  logic              wr_ctrl_i,
  input  logic              wr_tx_i,
  input  logic              rd_rx_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [CFG_W-1:0]  cfg_o,
  output logic [ST_W-1:0]   status_o,
  output logic              en_o,
  output logic [DATA_W-1:0] tx_data_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              busy_o,
  output logic              sclk_o,
  output logic              mosi_o,
  input  logic              miso_i,
  output logic              tx_dreq_o,
  output logic              rx_dreq_o,
  output logic              tx_empty_evt_o,
  output logic              rx_full_evt_o
);
  localparam int LEN_W = $clog2(DATA_W) + 1;

  logic [CFG_W-1:0]  cfg_q, cfg_d;
  logic              en_q, en_d;
  logic [ST_W-1:0]   st_q, st_d;
  logic [DATA_W-1:0] tx_q, tx_d, rx_q, rx_d;
  logic              pend_q, pend_d;

  logic              busy, done, capt, stall, start, trig, wire_en;
  logic [DATA_W-1:0] rx_word;
  logic [LEN_W-1:0]  len;
  xfer_mode_e        mode;

  assign mode    = xfer_mode_e'(cfg_q[CF_MODE_LSB +: 2]);
  assign len     = LEN_W'(cfg_q[CF_WL_LSB +: CF_WL_W]) + LEN_W'(1);
  assign stall   = (st_q[ST_TXE] && mode != XM_RX_ONLY) ||
                   (st_q[ST_RXF] && mode != XM_TX_ONLY && !cfg_q[CF_TURBO]);
  assign start   = pend_q && !busy && en_q && !stall;
  assign trig    = wr_tx_i || rd_rx_i || (wr_ctrl_i && wdata_i[0] && !en_q);
  assign wire_en = !single_mode_i || cfg_q[CF_FORCE];

  always_comb begin
    cfg_d  = cfg_q;
    en_d   = en_q;
    st_d   = st_q;
    tx_d   = tx_q;
    rx_d   = rx_q;
    pend_d = trig || (pend_q && busy);
    if (wr_cfg_i)  cfg_d = wdata_i[CFG_W-1:0];
    if (wr_ctrl_i) en_d  = wdata_i[0];
    if (start)     st_d[ST_EOT] = 1'b0;
    if (rd_rx_i)   st_d[ST_RXF] = 1'b0;
    if (done) begin
      st_d[ST_EOT] = 1'b1;
      st_d[ST_TXE] = 1'b1;
      if (mode != XM_TX_ONLY) st_d[ST_RXF] = 1'b1;
      tx_d = '0;
    end
    if (wr_tx_i) begin
      st_d[ST_TXE] = 1'b0;
      tx_d         = wdata_i;
    end
    if (capt) rx_d = rx_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= CFG_RST;
      en_q   <= 1'b0;
      st_q   <= ST_RST;
      tx_q   <= '0;
      rx_q   <= '0;
      pend_q <= 1'b0;
    end else begin
      cfg_q  <= cfg_d;
      en_q   <= en_d;
      st_q   <= st_d;
      tx_q   <= tx_d;
      rx_q   <= rx_d;
      pend_q <= pend_d;
    end
  end

  spi_seq_shift #(
    .DATA_W (DATA_W),
    .CLK_DIV(CLK_DIV),
    .LEN_W  (LEN_W)
  ) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start),
    .wire_i   (wire_en),
    .word_i   (tx_q),
    .len_i    (len),
    .miso_i   (miso_i),
    .busy_o   (busy),
    .sclk_o   (sclk_o),
    .mosi_o   (mosi_o),
    .done_o   (done),
    .capt_o   (capt),
    .rx_word_o(rx_word)
  );

  spi_seq_flags u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .en_i     (en_q),
    .mode_i   (mode),
    .turbo_i  (cfg_q[CF_TURBO]),
    .txdma_i  (cfg_q[CF_TXDMA]),
    .rxdma_i  (cfg_q[CF_RXDMA]),
    .stat_i   (st_q),
    .tx_dreq_o(tx_dreq_o),
    .rx_dreq_o(rx_dreq_o),
    .tx_evt_o (tx_empty_evt_o),
    .rx_evt_o (rx_full_evt_o)
  );

  assign cfg_o     = cfg_q;
  assign status_o  = st_q;
  assign en_o      = en_q;
  assign tx_data_o = tx_q;
  assign rx_data_o = rx_q;
  assign busy_o    = busy;
endmodule

// File: rtl/spi_chan_seq_chk.sv
module spi_chan_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_tx_i,
  input logic [22:0] cfg_o,
  input logic [2:0]  status_o,
  input logic        en_o,
  input logic        busy_o,
  input logic        sclk_o,
  input logic        tx_dreq_o,
  input logic        rx_dreq_o,
  input logic        tx_empty_evt_o,
  input logic        rx_full_evt_o
);
  // R7
  tx_dreq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_dreq_o |-> (en_o && status_o[1] && cfg_o[14]));

  // R7
  rx_dreq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_dreq_o |-> (en_o && status_o[0] && cfg_o[15]));

  // R9
  eot_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !status_o[2]);

  // R2
  sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !sclk_o);

  // R4
  no_start_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_o && !busy_o) |=> !busy_o);

  // R8
  tx_evt_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_empty_evt_o |=> !tx_empty_evt_o);

  // R8
  rx_evt_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_full_evt_o |=> !rx_full_evt_o);

  // R3
  done_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy_o) && !$past(wr_tx_i)) |-> (status_o[1] && status_o[2]));
endmodule

bind spi_chan_seq spi_chan_seq_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .wr_tx_i       (wr_tx_i),
  .cfg_o         (cfg_o),
  .status_o      (status_o),
  .en_o          (en_o),
  .busy_o        (busy_o),
  .sclk_o        (sclk_o),
  .tx_dreq_o     (tx_dreq_o),
  .rx_dreq_o     (rx_dreq_o),
  .tx_empty_evt_o(tx_empty_evt_o),
  .rx_full_evt_o (rx_full_evt_o)
);

// File: tb/test_spi_chan_seq.sv
module test_spi_chan_seq;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst_n;
  always #10 clk = ~clk;

  logic          single_mode, wr_cfg, wr_ctrl, wr_tx, rd_rx, miso;
  logic [DW-1:0] wdata;
  logic [22:0]   cfg;
  logic [2:0]    status;
  logic          en, busy, sclk, mosi, tx_dreq, rx_dreq, tx_evt, rx_evt;
  logic [DW-1:0] tx_data, rx_data;

  spi_chan_seq #(.DATA_W(DW), .CLK_DIV(2)) i_spi_chan_seq (
    .clk(clk), .rst_n(rst_n), .single_mode_i(single_mode),
    .wr_cfg_i(wr_cfg), .wr_ctrl_i(wr_ctrl), .wr_tx_i(wr_tx), .rd_rx_i(rd_rx),
    .wdata_i(wdata), .cfg_o(cfg), .status_o(status), .en_o(en),
    .tx_data_o(tx_data), .rx_data_o(rx_data), .busy_o(busy),
    .sclk_o(sclk), .mosi_o(mosi), .miso_i(miso),
    .tx_dreq_o(tx_dreq), .rx_dreq_o(rx_dreq),
    .tx_empty_evt_o(tx_evt), .rx_full_evt_o(rx_evt)
  );

  int n_chk = 0;
  int n_fail = 0;
  logic [31:0] exp_q[$];
  int txevt_cnt = 0;
  int edges = 0;
  logic busy_seen = 1'b0;
  logic [31:0] mosi_cap = '0;
  logic [31:0] slv_sh = '0;

  assign miso = slv_sh[31];

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  // serial slave model
  always @(posedge sclk) begin
    mosi_cap <= {mosi_cap[30:0], mosi};
    edges    <= edges + 1;
  end
  always @(negedge sclk) slv_sh <= slv_sh << 1;

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (busy) busy_seen = 1'b1;
      if (tx_evt) txevt_cnt++;
      if (rx_evt) begin
        if (exp_q.size() == 0) check(1'b0, "R8 unexpected rx event", rx_data, 32'h0);
        else begin
          logic [31:0] e;
          e = exp_q.pop_front();
          check(rx_data == e, "R2 received word", rx_data, e);
        end
      end
    end
  end

  function automatic logic [31:0] cw(int wl, int mode, bit turbo, bit force_b, bit txd, bit rxd);
    logic [31:0] v;
    v = '0;
    v[11:7]  = 5'(wl - 1);
    v[13:12] = 2'(mode);
    v[14]    = txd;
    v[15]    = rxd;
    v[19]    = turbo;
    v[20]    = force_b;
    return v;
  endfunction

  task automatic strobe_cfg(input logic [31:0] v);
    @(negedge clk); wr_cfg = 1'b1; wdata = v;
    @(negedge clk); wr_cfg = 1'b0;
  endtask
  task automatic strobe_ctrl(input logic [31:0] v);
    @(negedge clk); wr_ctrl = 1'b1; wdata = v;
    @(negedge clk); wr_ctrl = 1'b0;
  endtask
  task automatic strobe_tx(input logic [31:0] v);
    @(negedge clk); wr_tx = 1'b1; wdata = v;
    @(negedge clk); wr_tx = 1'b0;
  endtask
  task automatic strobe_rd();
    @(negedge clk); rd_rx = 1'b1;
    @(negedge clk); rd_rx = 1'b0;
  endtask
  task automatic prep(input logic [31:0] resp, input int wl);
    slv_sh   = resp << (32 - wl);
    mosi_cap = '0;
    edges    = 0;
  endtask
  task automatic wait_xfer(input string tag);
    int t;
    t = 0;
    while (!busy && t < 200) begin @(negedge clk); t++; end
    while (busy && t < 2000) begin @(negedge clk); t++; end
    if (t >= 200 && !busy_seen) check(1'b0, {tag, " no start"}, 0, 1);
    if (t >= 2000) check(1'b0, {tag, " no completion"}, 0, 1);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int ev0;
    rst_n = 1'b0; single_mode = 1'b0; wr_cfg = 1'b0; wr_ctrl = 1'b0;
    wr_tx = 1'b0; rd_rx = 1'b0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(status == 3'b010, "R1 status", 32'(status), 32'h2);
    check(cfg == 23'h060000, "R1 config", 32'(cfg), 32'h060000);
    check(!busy && !sclk && !en && !tx_dreq && !rx_dreq, "R1 idle outputs",
          {busy, sclk, en, tx_dreq, rx_dreq}, 0);
    check(tx_data == 0 && rx_data == 0, "R1 data regs", tx_data | rx_data, 0);

    // R10 config masking
    strobe_cfg(32'hFF80_0000 | cw(8, 0, 0, 0, 1, 1));
    check(32'(cfg) == cw(8, 0, 0, 0, 1, 1), "R10 config mask", 32'(cfg), cw(8, 0, 0, 0, 1, 1));

    // R8 enable rise gives transmit-empty event; R7 tx request
    ev0 = txevt_cnt;
    strobe_ctrl(32'h1);
    @(negedge clk);
    check(txevt_cnt == ev0 + 1, "R8 tx event on enable", txevt_cnt, ev0 + 1);
    check(tx_dreq && !rx_dreq, "R7 tx request level", {tx_dreq, rx_dreq}, 2'b10);

    // R2 R3 R9 duplex 8-bit word
    prep(32'h5A, 8);
    exp_q.push_back(32'h5A);
    strobe_tx(32'hA5);
    check(!tx_dreq, "R4 write clears transmit-empty", tx_dreq, 0);
    @(negedge clk);
    check(busy && !status[2], "R9 busy with eot clear", {busy, status[2]}, 2'b10);
    wait_xfer("R2");
    check(mosi_cap[7:0] == 8'hA5 && edges == 8, "R2 mosi word", {edges[7:0], mosi_cap[7:0]}, {8'd8, 8'hA5});
    check(status == 3'b111 && tx_data == 0, "R3 completion flags", {tx_data[28:0], status}, 3'b111);
    check(rx_dreq, "R7 rx request level", rx_dreq, 1);

    // R5 stall on unread word, R4 read restarts
    busy_seen = 1'b0;
    strobe_tx(32'h3C);
    repeat (12) @(negedge clk);
    check(!busy_seen && status[1] == 1'b0, "R5 receive-full stall", {busy_seen, status[1]}, 0);
    prep(32'hC3, 8);
    exp_q.push_back(32'hC3);
    strobe_rd();
    wait_xfer("R4");
    check(mosi_cap[7:0] == 8'h3C, "R4 read starts pending word", mosi_cap[7:0], 8'h3C);

    // R2 shortest word
    strobe_rd();
    strobe_cfg(cw(4, 0, 0, 0, 0, 0));
    prep(32'h9, 4);
    exp_q.push_back(32'h9);
    strobe_tx(32'h6);
    wait_xfer("R2 wl4");
    check(mosi_cap[3:0] == 4'h6 && edges == 4, "R2 4-bit word", {edges[3:0], mosi_cap[3:0]}, {4'd4, 4'h6});

    // R2 longest word
    strobe_rd();
    strobe_cfg(cw(32, 0, 0, 0, 0, 0));
    prep(32'h1234_5678, 32);
    exp_q.push_back(32'h1234_5678);
    strobe_tx(32'hDEAD_BEEF);
    wait_xfer("R2 wl32");
    check(mosi_cap == 32'hDEAD_BEEF && edges == 32, "R2 32-bit word", mosi_cap, 32'hDEAD_BEEF);

    // R5 turbo passes unread word, no event
    strobe_cfg(cw(8, 0, 1, 0, 0, 0));
    prep(32'h81, 8);
    strobe_tx(32'h42);
    wait_xfer("R5 turbo");
    check(rx_data == 32'h81 && status[0], "R5 turbo transfer", rx_data, 32'h81);

    // R3 transmit-only leaves receive-full clear
    strobe_cfg(cw(8, 2, 0, 0, 0, 1));
    strobe_rd();
    prep(32'h11, 8);
    strobe_tx(32'h24);
    wait_xfer("R3 tx-only");
    check(status == 3'b110 && !rx_dreq, "R3 tx-only flags", {rx_dreq, status}, 4'b0110);

    // R5 R7 receive-only starts on enable with transmit-empty set
    strobe_cfg(cw(8, 1, 0, 0, 1, 1));
    strobe_ctrl(32'h0);
    prep(32'hE7, 8);
    exp_q.push_back(32'hE7);
    strobe_ctrl(32'h1);
    wait_xfer("R5 rx-only");
    check(!tx_dreq && rx_dreq && status[1], "R7 rx-only requests", {tx_dreq, rx_dreq}, 2'b01);
    strobe_ctrl(32'h0);
    strobe_rd();

    // R4 no start while disabled, enable then starts it
    strobe_cfg(cw(8, 0, 0, 0, 0, 0));
    busy_seen = 1'b0;
    strobe_tx(32'h77);
    repeat (12) @(negedge clk);
    check(!busy_seen, "R4 disabled holds word", busy_seen, 0);
    prep(32'h5C, 8);
    exp_q.push_back(32'h5C);
    strobe_ctrl(32'h1);
    wait_xfer("R4 enable");
    check(mosi_cap[7:0] == 8'h77, "R4 enable starts word", mosi_cap[7:0], 8'h77);

    // R6 single-channel without force: no wire, rx unchanged
    strobe_rd();
    single_mode = 1'b1;
    prep(32'hAA, 8);
    exp_q.push_back(32'h5C);
    strobe_tx(32'h99);
    wait_xfer("R6");
    check(edges == 0 && status == 3'b111, "R6 no wire activity", {edges[28:0], status}, 3'b111);

    // R6 force bit restores wire
    strobe_rd();
    strobe_cfg(cw(8, 0, 0, 1, 0, 0));
    prep(32'h3E, 8);
    exp_q.push_back(32'h3E);
    strobe_tx(32'h18);
    wait_xfer("R6 force");
    check(edges == 8 && mosi_cap[7:0] == 8'h18, "R6 forced wire", {edges[7:0], mosi_cap[7:0]}, {8'd8, 8'h18});

    check(exp_q.size() == 0, "R8 all rx events seen", exp_q.size(), 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule